// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers a set of external interrupt lines and a group of on-chip interrupt sources. It masks them one source at a time and presents one winning source number to a processor as a vector. External lines come in asynchronously and pass through a two-stage synchroniser. Each external line can act as an active-low level request or as a falling-edge event that stays pending until software clears it. On-chip sources are always active-low level requests and are not synchronised.

Software reaches the block over a simple 32-bit register bus. A write completes in one cycle. A read returns its data one cycle after the request. Mask and pending bits are numbered from the most significant end, so source or line `n` sits at bit `31-n`. Source numbering works as follows: 0 is reserved as the "nothing pending" code; external line `k` is source `k+1`; on-chip source `j` is source `NUM_EXT+1+j`. With the default parameters the on-chip sources are numbers 9 to 24.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the mask, sense and pending registers read zero, the vector register reads zero and `irq_o` is low.
- R2: The mask register at offset 0x00 enables source `s` (1..24) through bit `31-s`. A clear bit keeps that source out of the vector. Bit 31 (source 0) and bits below source 24 always read zero.
- R3: In level mode an external line reads as pending while its synchronised input is low. `irq_o` responds two clock edges after the input changes. Writes to the pending register do not affect a level-mode line.
- R4: The sense register at offset 0x08 holds line 0 in bit 15 and line `k` in bit `15-k`. A 1 selects falling-edge detection and a 0 selects active-low level. All other bits read zero.
- R5: In edge mode, a high-to-low transition of the synchronised line sets a pending latch. The latch stays set after the line returns high. It is visible three clock edges after the input falls.
- R6: The pending register at offset 0x04 shows line `k` at bit `31-k`. Writing 1 to that bit clears the edge latch of line `k`. Writing 0 leaves it set.
- R7: On-chip sources are active-low level requests with no synchroniser. A low, unmasked source raises `irq_o` in the same cycle.
- R8: Among the sources that are both pending and unmasked, the lowest source number wins the vector.
- R9: The vector register at offset 0x0C returns the winning source number in bits 6:0, with all upper bits zero. A value of 0 means nothing is pending. `irq_o` is high exactly when the vector is non-zero.
- R10: Read data appears on `bus_rdata` one cycle after `bus_rd_en`. Unmapped or unaligned offsets read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | NUM_EXT | External interrupt lines, asynchronous, active low |
| int_irq_n | input | NUM_INT | On-chip interrupt sources, synchronous, active low |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The main function is tested with tables of input and mask patterns:
- a single pending source, to confirm the big-endian mask mapping;
- an external source and an on-chip source pending together, to confirm that the lowest number wins;
- a winner that is masked off, to confirm the next source takes over;
- the highest and lowest source numbers, to confirm the ends of the range;
- pending sources with every mask bit cleared, to confirm that masking blocks the vector.

The edge tests compare two cases on one line: a line that falls and rises again stays pending in edge mode, while a level-mode line follows its pin and ignores clear writes. The clear tests compare writing 0 with writing 1. The latency checks sample one cycle before and one cycle after the expected edge, which separates the synchronised path from the direct on-chip path.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned VEC_W  = 7;

  typedef enum logic [2:0] {
    SEL_MASK  = 3'd0,
    SEL_PEND  = 3'd1,
    SEL_SENSE = 3'd2,
    SEL_VEC   = 3'd3
  } ivc_sel_e;

  localparam int unsigned SENSE_TOP_BIT = 15;
endpackage

// File: rtl/ivc_line_sense.sv
module ivc_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pend_o
);
  logic s1_q, s2_q, s3_q, latch_q;
  logic latch_d, fall;

  assign fall = s3_q & ~s2_q;

  always_comb begin
    if (edge_mode_i) latch_d = (latch_q & ~clr_i) | fall;
    else             latch_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      s3_q    <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      s1_q    <= line_n_i;
      s2_q    <= s1_q;
      s3_q    <= s2_q;
      latch_q <= latch_d;
    end
  end

  assign pend_o = edge_mode_i ? latch_q : ~s2_q;

  // R5
  edge_sets_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode_i && fall) |=> latch_q);
  // R6
  clear_drops_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !fall) |=> !latch_q);
  // R3
  level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode_i |=> !latch_q);
endmodule

// File: rtl/ivc_prio_enc.sv
module ivc_prio_enc #(
  parameter int unsigned NSRC  = 25,
  parameter int unsigned VEC_W = 7
) (
  input  logic [NSRC-1:0]  req_i,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    for (int s = NSRC - 1; s >= 1; s--) begin
      if (req_i[s]) vec_o = VEC_W'(s);
    end
  end
endmodule

// File: rtl/ivc_regfile.sv
module ivc_regfile
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_EXT = 8,
  parameter int unsigned NSRC    = 25,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_EXT-1:0] ext_pend_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [NSRC-1:0]    mask_o,
  output logic [NUM_EXT-1:0] sense_o,
  output logic [NUM_EXT-1:0] clr_o
);
  logic [NSRC-1:0]    mask_q, mask_d;
  logic [NUM_EXT-1:0] sense_q, sense_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               mapped;
  logic [2:0]         word;
  logic               wdata_unused;

  assign wdata_unused = ^wdata_i;
  assign word   = addr_i[4:2];
  assign mapped = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:5] == '0)
                  && (word <= 3'(SEL_VEC));

  always_comb begin
    mask_d  = mask_q;
    sense_d = sense_q;
    if (wr_en_i && mapped && word == 3'(SEL_MASK)) begin
      for (int s = 1; s < NSRC; s++) mask_d[s] = wdata_i[DATA_W-1-s];
    end
    if (wr_en_i && mapped && word == 3'(SEL_SENSE)) begin
      for (int k = 0; k < NUM_EXT; k++) sense_d[k] = wdata_i[SENSE_TOP_BIT-k];
    end
    mask_d[0] = 1'b0;
  end

  always_comb begin
    for (int k = 0; k < NUM_EXT; k++)
      clr_o[k] = wr_en_i && mapped && (word == 3'(SEL_PEND)) && wdata_i[DATA_W-1-k];
  end

  always_comb begin
    rdata_d = '0;
    if (mapped) begin
      unique case (word)
        3'(SEL_MASK):  for (int s = 0; s < NSRC; s++) rdata_d[DATA_W-1-s] = mask_q[s];
        3'(SEL_PEND):  for (int k = 0; k < NUM_EXT; k++) rdata_d[DATA_W-1-k] = ext_pend_i[k];
        3'(SEL_SENSE): for (int k = 0; k < NUM_EXT; k++) rdata_d[SENSE_TOP_BIT-k] = sense_q[k];
        3'(SEL_VEC):   rdata_d[VEC_W-1:0] = vec_i;
        default:       rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      sense_q <= '0;
      rdata_q <= '0;
    end else begin
      mask_q  <= mask_d;
      sense_q <= sense_d;
      if (rd_en_i) rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign sense_o = sense_q;

  // R10
  unmapped_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !mapped) |=> ($stable(mask_q) && $stable(sense_q)));
  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !mapped) |=> (rdata_o == '0));
  // R2
  reserved_mask_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[0]);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_EXT = 8,
  parameter int unsigned NUM_INT = 16,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_irq_n,
  input  logic [NUM_INT-1:0] int_irq_n,
  input  logic               bus_wr_en,
  input  logic               bus_rd_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o
);
  localparam int unsigned NSRC  = 1 + NUM_EXT + NUM_INT;
  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned INT_BASE = 1 + NUM_EXT;

  logic [NSRC-1:0]    mask_w, pend_w, req_w;
  logic [NUM_EXT-1:0] sense_w, clr_w, ext_pend_w;
  logic [VEC_W-1:0]   vec_w;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_line
    ivc_line_sense u_sense (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_n_i    (ext_irq_n[k]),
      .edge_mode_i (sense_w[k]),
      .clr_i       (clr_w[k]),
      .pend_o      (ext_pend_w[k])
    );
  end

  always_comb begin
    pend_w    = '0;
    pend_w[NUM_EXT:1] = ext_pend_w;
    pend_w[NSRC-1:INT_BASE] = ~int_irq_n;
  end

  assign req_w = pend_w & mask_w;

  ivc_prio_enc #(.NSRC(NSRC), .VEC_W(VEC_W)) u_enc (
    .req_i (req_w),
    .vec_o (vec_w)
  );

  ivc_regfile #(.NUM_EXT(NUM_EXT), .NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (bus_wr_en),
    .rd_en_i    (bus_rd_en),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .ext_pend_i (ext_pend_w),
    .vec_i      (vec_w),
    .rdata_o    (bus_rdata),
    .mask_o     (mask_w),
    .sense_o    (sense_w),
    .clr_o      (clr_w)
  );

  assign irq_o = (vec_w != '0);

  // R2
  vector_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> mask_w[vec_w[IDX_W-1:0]]);
  // R8
  vector_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (((NSRC'(1) << vec_w[IDX_W-1:0]) - NSRC'(1)) & req_w) == '0);
  // R7
  internal_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~int_irq_n & mask_w[NSRC-1:INT_BASE])) |-> irq_o);
  // R9
  idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_w == '0) |-> !irq_o);
endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [4:0] A_MASK = 5'h00, A_PEND = 5'h04, A_SENSE = 5'h08,
                         A_VEC = 5'h0C, A_BAD = 5'h10;

  typedef struct packed {
    logic [7:0]  ext_n;
    logic [15:0] int_n;
    logic [31:0] mask;
    logic [6:0]  vec;
  } row_t;

  localparam int NROWS = 7;
  localparam row_t TBL [NROWS] = '{
    '{8'hFF, 16'hFFFF, 32'h7FFF_FF80, 7'd0},
    '{8'hFB, 16'hFFFF, 32'h7FFF_FF80, 7'd3},
    '{8'hFB, 16'hFFFE, 32'h7FFF_FF80, 7'd3},
    '{8'hFB, 16'hFFFE, 32'h6FFF_FF80, 7'd9},
    '{8'h7E, 16'hFFFF, 32'h0080_0000, 7'd8},
    '{8'hFF, 16'h7FFF, 32'h0000_0080, 7'd24},
    '{8'h00, 16'h0000, 32'h0000_0000, 7'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0]  ext_n;
  logic [15:0] int_n;
  logic wr, rd;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_n), .int_irq_n(int_n),
    .bus_wr_en(wr), .bus_rd_en(rd), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; ext_n = '1; int_n = '1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(A_MASK, d);  chk("R1 mask", d, 32'h0);
    bus_rd(A_SENSE, d); chk("R1 sense", d, 32'h0);
    bus_rd(A_PEND, d);  chk("R1 pend", d, 32'h0);
    bus_rd(A_VEC, d);   chk("R1 vector", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 reserved and unused mask bits
    bus_wr(A_MASK, 32'hFFFF_FFFF);
    bus_rd(A_MASK, d); chk("R2 mask readback", d, 32'h7FFF_FF80);

    // R2 R8 R9 table walk, level mode
    for (int i = 0; i < NROWS; i++) begin
      bus_wr(A_MASK, TBL[i].mask);
      @(negedge clk); ext_n = TBL[i].ext_n; int_n = TBL[i].int_n;
      idle(3);
      chk($sformatf("R9 irq row %0d", i), {31'b0, irq}, {31'b0, TBL[i].vec != 0});
      bus_rd(A_VEC, d);
      chk($sformatf("R8 vector row %0d", i), d, {25'b0, TBL[i].vec});
    end
    @(negedge clk); ext_n = '1; int_n = '1;
    idle(3);

    // R4 sense mapping: line 3 -> bit 12
    bus_wr(A_SENSE, 32'h0000_1000);
    bus_rd(A_SENSE, d); chk("R4 sense readback", d, 32'h0000_1000);

    // R5 edge latch on line 3 (source 4, mask bit 27)
    bus_wr(A_MASK, 32'h0800_0000);
    @(negedge clk); ext_n[3] = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R5 not yet latched", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R5 latched after three edges", {31'b0, irq}, 32'h1);
    idle(2); ext_n[3] = 1'b1; idle(5);
    bus_rd(A_PEND, d); chk("R5 pend held", d, 32'h1000_0000);
    bus_rd(A_VEC, d);  chk("R5 vector", d, 32'd4);

    // R6 write zero keeps, write one clears
    bus_wr(A_PEND, 32'h0000_0000);
    bus_rd(A_PEND, d); chk("R6 zero write keeps", d, 32'h1000_0000);
    bus_wr(A_PEND, 32'h1000_0000);
    bus_rd(A_PEND, d); chk("R6 one write clears", d, 32'h0);
    chk("R6 irq low", {31'b0, irq}, 32'h0);

    // R3 level line 5 (source 6, mask bit 25), latency and ignored clear
    bus_wr(A_SENSE, 32'h0);
    bus_wr(A_MASK, 32'h0200_0000);
    @(negedge clk); ext_n[5] = 1'b0;
    @(negedge clk); chk("R3 one edge", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R3 two edges", {31'b0, irq}, 32'h1);
    bus_wr(A_PEND, 32'hFFFF_FFFF);
    bus_rd(A_PEND, d); chk("R3 clear ignored", d, 32'h0400_0000);
    @(negedge clk); ext_n[5] = 1'b1; idle(3);
    bus_rd(A_PEND, d); chk("R3 follows pin", d, 32'h0);

    // R7 internal source 9 (mask bit 22) direct path
    bus_wr(A_MASK, 32'h0040_0000);
    @(negedge clk); int_n[0] = 1'b0; #1;
    chk("R7 same cycle", {31'b0, irq}, 32'h1);
    @(negedge clk); int_n[0] = 1'b1; #1;
    chk("R7 release", {31'b0, irq}, 32'h0);

    // R10 unmapped and unaligned
    bus_wr(A_BAD, 32'hFFFF_FFFF);
    bus_wr(5'h02, 32'hFFFF_FFFF);
    bus_rd(A_BAD, d);  chk("R10 unmapped read", d, 32'h0);
    bus_rd(5'h01, d);  chk("R10 unaligned read", d, 32'h0);
    bus_rd(A_MASK, d); chk("R10 mask untouched", d, 32'h0040_0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule